// File: doc/BRIEF.md
# Bridge Posted-Write Ordering Controller

This block decides when a new transaction may start on either side of a two-bus bridge. One side faces the processor and the other faces a PCI bus. Each direction has its own posted-write FIFO. The block models each FIFO only as an occupancy count, driven by push and pop strobes. From these counts it grants or stalls each side's pending request, so that transactions complete on the destination bus in the order they completed on the originating bus.

A posted write may enter its FIFO freely, except when the opposite side holds a stalled read that is waiting for that same FIFO to empty. In that case the write is refused, so the read cannot be starved. Reads, compelled writes and internal register or configuration accesses wait until the FIFOs they depend on are empty. Two separate enable inputs add flush-before-read behaviour: one for processor-originated reads and one for PCI-originated reads. Each works without regard to the other.

The block also drives a speculative bus request toward the PCI arbiter while a processor-to-PCI write is pending. The request is withdrawn after a fixed number of clocks, or earlier if the pending indication or the mode enable goes away. It stays low for at least one clock before it may be raised again.

Top module: `bridge_order_ctl`

## Requirements
- R1: Each occupancy count is 0 after reset. A push alone adds one, a pop alone subtracts one, and push and pop in the same cycle leave the count unchanged. The counts are visible on `c2pCount` and `p2cCount`.
- R2: Kind codes are 0 = posted write, 1 = read, 2 = compelled write and 3 = register access (on the PCI side, an internal configuration access). On the processor side, a read or compelled write is granted only while the processor-to-PCI count is 0.
- R3: A processor register access (kind 3) is granted only while the processor-to-PCI count is 0.
- R4: A PCI configuration access (kind 3) is granted only while both counts are 0.
- R5: When `cfgCpuFlushRd` is 1, a processor read additionally needs the PCI-to-processor count to be 0. When it is 0, that count has no effect on processor reads.
- R6: When `cfgPciFlushRd` is 1, a PCI read additionally needs the processor-to-PCI count to be 0. When it is 0, that count has no effect on PCI reads.
- R7: A PCI read or compelled write is granted only while the PCI-to-processor count is 0.
- R8: Grants and stalls are combinational from the request inputs and the counts. For each side, grant = req and conditions met, and stall = req and not conditions met. Both are 0 without a request.
- R9: A posted write (kind 0) is refused with a stall while the opposite side is stalled on a request that depends on that write's FIFO. The processor posted write depends on a stalled PCI flush-enabled read or PCI configuration access. The PCI posted write depends on a stalled processor flush-enabled read.
- R10: With `cfgSpecEn` and `specWant` both high, `specReq` rises one clock after they are sampled. It stays high for exactly 16 clocks and is then withdrawn.
- R11: After each withdrawal, `specReq` is low for exactly one clock before it rises again, if `specWant` and `cfgSpecEn` are still high.
- R12: Clearing `cfgSpecEn` or `specWant` drops `specReq` at the next clock. With `cfgSpecEn` low, `specReq` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCpuFlushRd | input | 1 | Processor reads also drain the PCI-to-processor FIFO |
| cfgPciFlushRd | input | 1 | PCI reads also drain the processor-to-PCI FIFO |
| cfgSpecEn | input | 1 | Speculative request mode enable |
| cpuReq | input | 1 | Processor side has a transaction pending |
| cpuKind | input | 2 | Processor transaction kind code |
| pciReq | input | 1 | PCI side has a transaction pending |
| pciKind | input | 2 | PCI transaction kind code |
| c2pPush | input | 1 | Processor-to-PCI FIFO push strobe |
| c2pPop | input | 1 | Processor-to-PCI FIFO pop strobe |
| p2cPush | input | 1 | PCI-to-processor FIFO push strobe |
| p2cPop | input | 1 | PCI-to-processor FIFO pop strobe |
| specWant | input | 1 | A processor write bound for PCI is pending |
| cpuGrant | output | 1 | Processor transaction may start |
| cpuStall | output | 1 | Processor transaction is held |
| pciGrant | output | 1 | PCI transaction may start |
| pciStall | output | 1 | PCI transaction is held |
| c2pCount | output | CNT_W | Processor-to-PCI occupancy |
| p2cCount | output | CNT_W | PCI-to-processor occupancy |
| specReq | output | 1 | Speculative request toward the PCI arbiter |

## Verification
The assertions take for granted that the FIFO strobes are sane: no pop arrives while a count is 0, and no push arrives while a count is at full depth. Under that assumption the counts never wrap. The stimulus keeps to this by moving each count toward its target one step at a time, between 0 and 2. It holds push and pop low while it sweeps every combination of request, kind and flush enable for each count pair. The speculative-request checks drive the want and enable inputs directly, with both FIFOs idle.

// File: rtl/bridge_order_pkg.sv
package bridge_order_pkg;

  typedef enum logic [1:0] {
    KIND_POST = 2'd0,
    KIND_READ = 2'd1,
    KIND_COMP = 2'd2,
    KIND_REG  = 2'd3
  } xferKind_e;

  typedef enum logic [1:0] {
    SPEC_IDLE = 2'd0,
    SPEC_ON   = 2'd1,
    SPEC_GAP  = 2'd2
  } specState_e;

  typedef struct packed {
    logic specClr;
    logic specInc;
  } ctlStrobes_t;

endpackage

// File: rtl/bridge_occ_counter.sv
module bridge_occ_counter #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic             empty
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign empty = (count == '0);

endmodule

// File: rtl/bridge_order_dp.sv
module bridge_order_dp
  import bridge_order_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int SPEC_LIMIT = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SPEC_W = $clog2(SPEC_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             c2pPush,
  input  logic             c2pPop,
  input  logic             p2cPush,
  input  logic             p2cPop,
  input  ctlStrobes_t      strb,
  output logic [CNT_W-1:0] c2pCount,
  output logic [CNT_W-1:0] p2cCount,
  output logic             c2pEmpty,
  output logic             p2cEmpty,
  output logic             specAtLimit
);

  localparam int NDIR = 2;

  logic [NDIR-1:0]            pushVec;
  logic [NDIR-1:0]            popVec;
  logic [NDIR-1:0][CNT_W-1:0] cntVec;
  logic [NDIR-1:0]            emptyVec;
  logic [SPEC_W-1:0]          specCnt;

  assign pushVec = {p2cPush, c2pPush};
  assign popVec  = {p2cPop, c2pPop};

  for (genvar d = 0; d < NDIR; d++) begin : gDir
    bridge_occ_counter #(.DEPTH(DEPTH)) uCnt (
      .clk  (clk),
      .rstN (rstN),
      .push (pushVec[d]),
      .pop  (popVec[d]),
      .count(cntVec[d]),
      .empty(emptyVec[d])
    );
  end

  assign c2pCount = cntVec[0];
  assign p2cCount = cntVec[1];
  assign c2pEmpty = emptyVec[0];
  assign p2cEmpty = emptyVec[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      specCnt <= '0;
    end else if (strb.specClr) begin
      specCnt <= '0;
    end else if (strb.specInc) begin
      specCnt <= specCnt + SPEC_W'(1);
    end
  end

  assign specAtLimit = (specCnt == SPEC_W'(SPEC_LIMIT - 1));

endmodule

// File: rtl/bridge_order_ctrl.sv
module bridge_order_ctrl
  import bridge_order_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgCpuFlushRd,
  input  logic        cfgPciFlushRd,
  input  logic        cfgSpecEn,
  input  logic        cpuReq,
  input  logic [1:0]  cpuKind,
  input  logic        pciReq,
  input  logic [1:0]  pciKind,
  input  logic        c2pEmpty,
  input  logic        p2cEmpty,
  input  logic        specWant,
  input  logic        specAtLimit,
  output logic        cpuGrant,
  output logic        cpuStall,
  output logic        pciGrant,
  output logic        pciStall,
  output logic        specReq,
  output ctlStrobes_t strb
);

  xferKind_e  cpuK;
  xferKind_e  pciK;
  logic       cpuReadOk;
  logic       cpuOtherOk;
  logic       pciReadOk;
  logic       pciOtherOk;
  logic       blockC2p;
  logic       blockP2c;
  logic       cpuOk;
  logic       pciOk;
  specState_e specState;
  specState_e specNext;
  logic       specGo;

  assign cpuK = xferKind_e'(cpuKind);
  assign pciK = xferKind_e'(pciKind);

  // Ordering conditions that depend only on FIFO occupancy.
  assign cpuReadOk  = c2pEmpty && (!cfgCpuFlushRd || p2cEmpty);
  assign cpuOtherOk = c2pEmpty;
  assign pciReadOk  = p2cEmpty && (!cfgPciFlushRd || c2pEmpty);

  always_comb begin
    case (pciK)
      KIND_REG: pciOtherOk = c2pEmpty && p2cEmpty;
      default:  pciOtherOk = p2cEmpty;
    endcase
  end

  // A stalled request that waits for the opposite FIFO closes that FIFO's entry.
  assign blockC2p = pciReq && (
                      ((pciK == KIND_READ) && cfgPciFlushRd && !pciReadOk) ||
                      ((pciK == KIND_REG) && !pciOtherOk));
  assign blockP2c = cpuReq && (cpuK == KIND_READ) && cfgCpuFlushRd && !cpuReadOk;

  always_comb begin
    case (cpuK)
      KIND_POST: cpuOk = !blockC2p;
      KIND_READ: cpuOk = cpuReadOk;
      default:   cpuOk = cpuOtherOk;
    endcase
  end

  always_comb begin
    case (pciK)
      KIND_POST: pciOk = !blockP2c;
      KIND_READ: pciOk = pciReadOk;
      default:   pciOk = pciOtherOk;
    endcase
  end

  assign cpuGrant = cpuReq && cpuOk;
  assign cpuStall = cpuReq && !cpuOk;
  assign pciGrant = pciReq && pciOk;
  assign pciStall = pciReq && !pciOk;

  // Speculative request sequencer.
  assign specGo = specWant && cfgSpecEn;

  always_comb begin
    specNext     = specState;
    strb.specClr = 1'b0;
    strb.specInc = 1'b0;
    case (specState)
      SPEC_IDLE: begin
        if (specGo) begin
          specNext     = SPEC_ON;
          strb.specClr = 1'b1;
        end
      end
      SPEC_ON: begin
        if (!specGo || specAtLimit) begin
          specNext = SPEC_GAP;
        end else begin
          strb.specInc = 1'b1;
        end
      end
      SPEC_GAP: begin
        if (specGo) begin
          specNext     = SPEC_ON;
          strb.specClr = 1'b1;
        end else begin
          specNext = SPEC_IDLE;
        end
      end
      default: specNext = SPEC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      specState <= SPEC_IDLE;
    end else begin
      specState <= specNext;
    end
  end

  assign specReq = (specState == SPEC_ON);

endmodule

// File: rtl/bridge_order_ctl.sv
module bridge_order_ctl
  import bridge_order_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int SPEC_LIMIT = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCpuFlushRd,
  input  logic             cfgPciFlushRd,
  input  logic             cfgSpecEn,
  input  logic             cpuReq,
  input  logic [1:0]       cpuKind,
  input  logic             pciReq,
  input  logic [1:0]       pciKind,
  input  logic             c2pPush,
  input  logic             c2pPop,
  input  logic             p2cPush,
  input  logic             p2cPop,
  input  logic             specWant,
  output logic             cpuGrant,
  output logic             cpuStall,
  output logic             pciGrant,
  output logic             pciStall,
  output logic [CNT_W-1:0] c2pCount,
  output logic [CNT_W-1:0] p2cCount,
  output logic             specReq
);

  ctlStrobes_t strb;
  logic        c2pEmpty;
  logic        p2cEmpty;
  logic        specAtLimit;

  bridge_order_dp #(.DEPTH(DEPTH), .SPEC_LIMIT(SPEC_LIMIT)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .c2pPush    (c2pPush),
    .c2pPop     (c2pPop),
    .p2cPush    (p2cPush),
    .p2cPop     (p2cPop),
    .strb       (strb),
    .c2pCount   (c2pCount),
    .p2cCount   (p2cCount),
    .c2pEmpty   (c2pEmpty),
    .p2cEmpty   (p2cEmpty),
    .specAtLimit(specAtLimit)
  );

  bridge_order_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgCpuFlushRd(cfgCpuFlushRd),
    .cfgPciFlushRd(cfgPciFlushRd),
    .cfgSpecEn    (cfgSpecEn),
    .cpuReq       (cpuReq),
    .cpuKind      (cpuKind),
    .pciReq       (pciReq),
    .pciKind      (pciKind),
    .c2pEmpty     (c2pEmpty),
    .p2cEmpty     (p2cEmpty),
    .specWant     (specWant),
    .specAtLimit  (specAtLimit),
    .cpuGrant     (cpuGrant),
    .cpuStall     (cpuStall),
    .pciGrant     (pciGrant),
    .pciStall     (pciStall),
    .specReq      (specReq),
    .strb         (strb)
  );

endmodule

// File: rtl/bridge_order_chk.sv
module bridge_order_chk #(
  parameter int DEPTH      = 8,
  parameter int SPEC_LIMIT = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int RUN_W = $clog2(SPEC_LIMIT + 2)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgCpuFlushRd,
  input logic             cfgPciFlushRd,
  input logic             cfgSpecEn,
  input logic             cpuReq,
  input logic [1:0]       cpuKind,
  input logic             pciReq,
  input logic [1:0]       pciKind,
  input logic             c2pPush,
  input logic             c2pPop,
  input logic             p2cPush,
  input logic             p2cPop,
  input logic             specWant,
  input logic             cpuGrant,
  input logic             cpuStall,
  input logic             pciGrant,
  input logic             pciStall,
  input logic [CNT_W-1:0] c2pCount,
  input logic [CNT_W-1:0] p2cCount,
  input logic             specReq
);

  logic [RUN_W-1:0] hiRun;

  always_ff @(posedge clk) begin
    if (!rstN) hiRun <= '0;
    else if (specReq) hiRun <= hiRun + RUN_W'(1);
    else hiRun <= '0;
  end

  // Input assumptions: strobes never underflow or overflow a count.
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (c2pCount == '0) |-> !(c2pPop && !c2pPush));
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (p2cCount == CNT_W'(DEPTH)) |-> !(p2cPush && !p2cPop));

  a_r1_c2p_inc: assert property (@(posedge clk) disable iff (!rstN)
    (c2pPush && !c2pPop) |=> (c2pCount == $past(c2pCount) + CNT_W'(1)));
  a_r1_p2c_dec: assert property (@(posedge clk) disable iff (!rstN)
    (p2cPop && !p2cPush) |=> (p2cCount == $past(p2cCount) - CNT_W'(1)));

  a_r2_cpu_order: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGrant && (cpuKind != 2'd0)) |-> (c2pCount == '0));
  a_r4_cfg_drain: assert property (@(posedge clk) disable iff (!rstN)
    (pciGrant && (pciKind == 2'd3)) |-> ((c2pCount == '0) && (p2cCount == '0)));
  a_r5_cpu_flush: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGrant && (cpuKind == 2'd1) && cfgCpuFlushRd) |-> (p2cCount == '0));
  a_r6_pci_flush: assert property (@(posedge clk) disable iff (!rstN)
    (pciGrant && (pciKind == 2'd1) && cfgPciFlushRd) |-> (c2pCount == '0));
  a_r7_pci_order: assert property (@(posedge clk) disable iff (!rstN)
    (pciGrant && (pciKind == 2'd1 || pciKind == 2'd2)) |-> (p2cCount == '0));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuGrant && cpuStall) && !(pciGrant && pciStall));
  a_r8_need_req: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuGrant || cpuStall) |-> cpuReq) and ((pciGrant || pciStall) |-> pciReq));
  a_r9_block_c2p: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGrant && (cpuKind == 2'd0)) |-> !(pciStall && (pciKind == 2'd3)));
  a_r10_limit: assert property (@(posedge clk) disable iff (!rstN)
    specReq |-> (hiRun < RUN_W'(SPEC_LIMIT)));
  a_r12_disable: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSpecEn |=> !specReq);

endmodule

bind bridge_order_ctl bridge_order_chk #(.DEPTH(DEPTH), .SPEC_LIMIT(SPEC_LIMIT)) uChk (.*);

// File: tb/bridge_order_ctl_test.sv
`timescale 1ns/1ps
module bridge_order_ctl_test;

  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LIM   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgCpuFlushRd = 1'b0, cfgPciFlushRd = 1'b0, cfgSpecEn = 1'b0;
  logic cpuReq = 1'b0, pciReq = 1'b0;
  logic [1:0] cpuKind = 2'd0, pciKind = 2'd0;
  logic c2pPush = 1'b0, c2pPop = 1'b0, p2cPush = 1'b0, p2cPop = 1'b0;
  logic specWant = 1'b0;
  logic cpuGrant, cpuStall, pciGrant, pciStall, specReq;
  logic [CNT_W-1:0] c2pCount, p2cCount;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  bridge_order_ctl #(.DEPTH(DEPTH), .SPEC_LIMIT(LIM)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Move counts one step per clock toward targets, checking each step (R1).
  task automatic setCounts(input int tc, input int tp);
    int mc = int'(c2pCount);
    int mp = int'(p2cCount);
    while (mc != tc || mp != tp) begin
      c2pPush = (mc < tc); c2pPop = (mc > tc);
      p2cPush = (mp < tp); p2cPop = (mp > tp);
      if (mc < tc) mc++; else if (mc > tc) mc--;
      if (mp < tp) mp++; else if (mp > tp) mp--;
      step();
      c2pPush = 0; c2pPop = 0; p2cPush = 0; p2cPop = 0;
      #2;
      check("R1 c2pCount", int'(c2pCount), mc);
      check("R1 p2cCount", int'(p2cCount), mp);
    end
  endtask

  function automatic logic [3:0] model(input int c, input int p,
      input logic fc, input logic fp, input logic cr, input logic [1:0] ck,
      input logic pr, input logic [1:0] pk);
    logic cRd, pRd, pOther, blkC, blkP, cOk, pOk;
    cRd    = (c == 0) && (!fc || p == 0);
    pRd    = (p == 0) && (!fp || c == 0);
    pOther = (pk == 2'd3) ? (c == 0 && p == 0) : (p == 0);
    blkC   = pr && (((pk == 2'd1) && fp && !pRd) || ((pk == 2'd3) && !pOther));
    blkP   = cr && (ck == 2'd1) && fc && !cRd;
    cOk    = (ck == 2'd0) ? !blkC : (ck == 2'd1) ? cRd : (c == 0);
    pOk    = (pk == 2'd0) ? !blkP : (pk == 2'd1) ? pRd : pOther;
    return {cr && cOk, cr && !cOk, pr && pOk, pr && !pOk};
  endfunction

  initial begin : watchdog
    #(5ns * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    #2;
    check("R1 reset c2p", int'(c2pCount), 0);
    check("R1 reset p2c", int'(p2cCount), 0);
    check("R12 reset specReq", int'(specReq), 0);
    check("R8 reset idle", int'({cpuGrant, cpuStall, pciGrant, pciStall}), 0);

    // Simultaneous push and pop keep the count (R1).
    setCounts(2, 1);
    step();
    c2pPush = 1; c2pPop = 1; p2cPush = 1; p2cPop = 1;
    step();
    c2pPush = 0; c2pPop = 0; p2cPush = 0; p2cPop = 0;
    #2;
    check("R1 push+pop c2p", int'(c2pCount), 2);
    check("R1 push+pop p2c", int'(p2cCount), 1);

    // Sweep of ordering rules: R2 R3 R4 R5 R6 R7 R8 R9.
    for (int c = 0; c < 3; c++) begin
      for (int p = 0; p < 3; p++) begin
        setCounts(c, p);
        for (int v = 0; v < 256; v++) begin
          step();
          cfgCpuFlushRd = v[0]; cfgPciFlushRd = v[1];
          cpuReq = v[2]; pciReq = v[3];
          cpuKind = v[5:4]; pciKind = v[7:6];
          #2;
          check("R2/R3/R4/R5/R6/R7/R8/R9 grant-stall",
                int'({cpuGrant, cpuStall, pciGrant, pciStall}),
                int'(model(c, p, cfgCpuFlushRd, cfgPciFlushRd,
                           cpuReq, cpuKind, pciReq, pciKind)));
        end
      end
    end
    step();
    cpuReq = 0; pciReq = 0;
    setCounts(0, 0);

    // R12: enable low, want high -> never raised.
    step();
    specWant = 1; cfgSpecEn = 0;
    for (int i = 0; i < 5; i++) begin
      step(); #2;
      check("R12 disabled no request", int'(specReq), 0);
    end

    // R10/R11: 16 high, one low, repeated.
    step();
    cfgSpecEn = 1;
    for (int i = 0; i < 3 * (LIM + 1); i++) begin
      step(); #2;
      check((i % (LIM + 1) < LIM) ? "R10 request window" : "R11 idle gap",
            int'(specReq), (i % (LIM + 1) < LIM) ? 1 : 0);
    end

    // R12: clearing enable mid-request drops it next clock.
    step(); #2;
    check("R10 re-raised", int'(specReq), 1);
    cfgSpecEn = 0;
    step(); #2;
    check("R12 enable cleared", int'(specReq), 0);
    cfgSpecEn = 1;
    step(); #2;
    step(); #2;
    check("R10 raised again", int'(specReq), 1);
    specWant = 0;
    step(); #2;
    check("R12 want cleared", int'(specReq), 0);
    step(); #2;
    check("R12 stays low", int'(specReq), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule